// File: doc/BRIEF.md
# L1 Cache Timing Model with Immediate and Delayed Responses

This block models the timing of a direct-mapped L1 cache for a pipeline memory stage. It holds no data. It keeps a tag, a valid bit and a fill-pending bit for each line, plus a small pool of outstanding-miss slots. Each accepted request gets a classification code in the same cycle. When a request has to wait for a fill, its completion comes back later on a separate delayed-response channel, carrying the request ID.

Main memory is modelled as a fixed latency of `MISS_LAT` cycles. The request set covers ordinary accesses (load, store, prefetch). It also covers maintenance operations: invalidate one line, invalidate every line, flush one line, flush every line, and kill every outstanding miss. The request port uses a valid/ready handshake. `req_ready` is always high, because a request that cannot be served is still accepted and answered with a retry code; the issuer must send it again in a later cycle. The delayed channel also uses valid/ready. A presented response holds steady until the cycle in which `dly_ready` is high.

Top module: `l1_timing_cache`

## Requirements
- R1: `req_ready` is always 1 and `imm_valid` follows `req_valid`. `imm_code` is a combinational function of the current request and state. Request kinds are encoded as LOAD=0, STORE=1, PREFETCH=2, INV_LINE=3, INV_ALL=4, KILL_ALL=5, FLUSH_LINE=6, FLUSH_ALL=7. Immediate codes are HIT=0, HIT_SERVICING=1, MISS_SERVICING=2, MISS_RETRY=3. After reset no delayed response is valid.
- R2: A LOAD, STORE or PREFETCH to a present line with no fill pending returns HIT and allocates nothing.
- R3: A LOAD, STORE or PREFETCH that misses while a slot is free returns MISS_SERVICING and installs the line as pending. A delayed response with code MISS_RESPONSE (0) and the request's ID becomes valid exactly `MISS_LAT` clock edges after the accepting edge.
- R4: An access to a line whose fill is still pending returns HIT_SERVICING when a slot is free. Its HIT_RESPONSE (code 1), carrying its own ID, becomes available in the same cycle as the fill's MISS_RESPONSE.
- R5: MISS_RETRY is returned, and no state changes, in either of these cases: no slot is free for a miss or a pending hit; or the miss indexes a line whose pending fill has a different tag.
- R6: While `dly_valid` is high and `dly_ready` is low, the delayed code and ID stay unchanged. A response leaves the channel on a cycle with `dly_ready` high. Among completed slots, the lowest-numbered slot is presented first.
- R7: INV_LINE returns HIT. It clears the addressed line only when the tag matches; a line with another tag stays present.
- R8: INV_ALL returns HIT and leaves every line absent.
- R9: KILL_ALL returns HIT and frees every slot without producing a delayed response. Lines whose fill was pending become absent.
- R10: FLUSH_LINE returns HIT and clears the line when it is present. Otherwise it returns MISS_SERVICING without using a slot.
- R11: FLUSH_ALL clears all lines. It returns HIT when at least one line was present and MISS_SERVICING when none was.
- R12: Address bits [OFF_W-1:0] select the byte within a line and are ignored, the next IDX_W bits select the line, and the upper bits are the tag. Two addresses with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_kind | input | 3 | Request kind |
| req_addr | input | ADDR_W | Byte address |
| req_id | input | ID_W | Request identifier |
| imm_valid | output | 1 | Immediate classification valid |
| imm_code | output | 2 | Immediate classification |
| dly_valid | output | 1 | Delayed response present |
| dly_ready | input | 1 | Delayed response taken |
| dly_code | output | 1 | 0 = miss response, 1 = hit response |
| dly_id | output | ID_W | ID of the completed request |

## Verification
A wrong tag, valid bit or pending bit appears on `imm_code` the first time the same line is addressed again: a hit that should be a miss, or a servicing code where a plain hit belongs. A slot left busy, freed too early or timed wrongly shows up in one of two ways. Either a retry appears where a free slot was expected, or `dly_valid` rises one or more cycles off the exact latency. The tests count edges so that a response that is early or late by a single cycle is caught.

// File: rtl/l1tm_pkg.sv
package l1tm_pkg;
  typedef enum logic [2:0] {
    RQ_LOAD       = 3'd0,
    RQ_STORE      = 3'd1,
    RQ_PREFETCH   = 3'd2,
    RQ_INV_LINE   = 3'd3,
    RQ_INV_ALL    = 3'd4,
    RQ_KILL_ALL   = 3'd5,
    RQ_FLUSH_LINE = 3'd6,
    RQ_FLUSH_ALL  = 3'd7
  } req_kind_e;

  typedef enum logic [1:0] {
    IM_HIT        = 2'd0,
    IM_HIT_SERV   = 2'd1,
    IM_MISS_SERV  = 2'd2,
    IM_MISS_RETRY = 2'd3
  } imm_code_e;

  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_WAIT = 2'd1,
    SL_DONE = 2'd2
  } slot_st_e;
endpackage

// File: rtl/l1tm_tag_array.sv
module l1tm_tag_array #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 9,
  parameter int SLOTS  = 2,
  parameter int IDX_W  = $clog2(LINES),
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic              lk_pend,
  output logic              lk_busy,
  output logic [SLOT_W-1:0] lk_slot,
  output logic              any_valid,
  input  logic              fill_en,
  input  logic [SLOT_W-1:0] fill_slot,
  input  logic              inv_line_en,
  input  logic              inv_all_en,
  input  logic              kill_en,
  input  logic [SLOTS-1:0]  done_mask
);
  logic [LINES-1:0]  valid_q, pend_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [SLOT_W-1:0] slot_q [LINES];

  logic tag_eq;
  assign tag_eq    = (tag_q[lk_idx] == lk_tag);
  assign lk_hit    = valid_q[lk_idx] && tag_eq;
  assign lk_pend   = pend_q[lk_idx];
  assign lk_busy   = pend_q[lk_idx] && !tag_eq;
  assign lk_slot   = slot_q[lk_idx];
  assign any_valid = |valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      pend_q  <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        slot_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        // a fill completing releases only the line it belongs to
        if (pend_q[i] && done_mask[slot_q[i]]) pend_q[i] <= 1'b0;
        if (inv_all_en || (kill_en && pend_q[i]) ||
            (inv_line_en && lk_idx == IDX_W'(i))) begin
          valid_q[i] <= 1'b0;
          pend_q[i]  <= 1'b0;
        end
        if (fill_en && lk_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          pend_q[i]  <= 1'b1;
          tag_q[i]   <= lk_tag;
          slot_q[i]  <= fill_slot;
        end
      end
    end
  end

  assert_inv_all_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_en |=> !any_valid);
  assert_kill_drops_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill_en |=> (pend_q == '0));
endmodule

// File: rtl/l1tm_miss_slots.sv
module l1tm_miss_slots
  import l1tm_pkg::*;
#(
  parameter int SLOTS  = 2,
  parameter int ID_W   = 4,
  parameter int LAT    = 4,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int CNT_W  = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic              alloc_hitresp,
  input  logic [CNT_W-1:0]  alloc_cnt,
  input  logic              kill_en,
  input  logic [SLOT_W-1:0] q_slot,
  output logic [CNT_W-1:0]  q_cnt,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_slot,
  output logic [SLOTS-1:0]  done_mask,
  output logic              dly_valid,
  input  logic              dly_ready,
  output logic              dly_hitresp,
  output logic [ID_W-1:0]   dly_id
);
  slot_st_e          st_q  [SLOTS];
  logic [CNT_W-1:0]  cnt_q [SLOTS];
  logic [ID_W-1:0]   id_q  [SLOTS];
  logic [SLOTS-1:0]  hr_q;
  logic              lock_q;
  logic [SLOT_W-1:0] lock_slot_q;

  logic              done_any;
  logic [SLOT_W-1:0] done_slot, sel;
  logic              pop;

  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    done_any  = 1'b0;
    done_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (st_q[s] == SL_FREE) begin free_any = 1'b1; free_slot = SLOT_W'(s); end
      if (st_q[s] == SL_DONE) begin done_any = 1'b1; done_slot = SLOT_W'(s); end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_done
    assign done_mask[s] = (st_q[s] == SL_WAIT) && (cnt_q[s] == CNT_W'(1));
  end

  assign q_cnt       = cnt_q[q_slot];
  assign sel         = lock_q ? lock_slot_q : done_slot;
  assign dly_valid   = lock_q || done_any;
  assign dly_hitresp = hr_q[sel];
  assign dly_id      = id_q[sel];
  assign pop         = dly_valid && dly_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q      <= 1'b0;
      lock_slot_q <= '0;
      hr_q        <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        st_q[s]  <= SL_FREE;
        cnt_q[s] <= '0;
        id_q[s]  <= '0;
      end
    end else begin
      lock_q      <= dly_valid && !dly_ready && !kill_en;
      lock_slot_q <= sel;
      for (int s = 0; s < SLOTS; s++) begin
        if (kill_en) begin
          st_q[s] <= SL_FREE;
        end else begin
          if (st_q[s] == SL_WAIT) begin
            cnt_q[s] <= cnt_q[s] - CNT_W'(1);
            if (cnt_q[s] == CNT_W'(1)) st_q[s] <= SL_DONE;
          end
          if (pop && sel == SLOT_W'(s)) st_q[s] <= SL_FREE;
          if (alloc_en && free_slot == SLOT_W'(s)) begin
            id_q[s]  <= alloc_id;
            hr_q[s]  <= alloc_hitresp;
            cnt_q[s] <= alloc_cnt;
            st_q[s]  <= (alloc_cnt == '0) ? SL_DONE : SL_WAIT;
          end
        end
      end
    end
  end

  assert_alloc_needs_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> free_any);
  assert_kill_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill_en |=> !dly_valid);
  assert_dly_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_valid && !dly_ready && !kill_en) |=>
      (dly_valid && $stable(dly_id) && $stable(dly_hitresp)));
endmodule

// File: rtl/l1_timing_cache.sv
module l1_timing_cache
  import l1tm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 16,
  parameter int ID_W       = 4,
  parameter int SLOTS      = 2,
  parameter int MISS_LAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              imm_valid,
  output logic [1:0]        imm_code,
  output logic              dly_valid,
  input  logic              dly_ready,
  output logic              dly_code,
  output logic [ID_W-1:0]   dly_id
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(MISS_LAT + 1);

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              unused_offset;
  assign idx           = req_addr[OFF_W +: IDX_W];
  assign tag           = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^req_addr[OFF_W-1:0];

  logic              lk_hit, lk_pend, lk_busy, any_valid;
  logic [SLOT_W-1:0] lk_slot, free_slot;
  logic [CNT_W-1:0]  q_cnt, alloc_cnt;
  logic              free_any;
  logic [SLOTS-1:0]  done_mask;
  logic              alloc_en, alloc_hr, fill_en, inv_line_en, inv_all_en, kill_en;
  imm_code_e         code;
  req_kind_e         kind;

  assign kind      = req_kind_e'(req_kind);
  assign req_ready = 1'b1;
  assign imm_valid = req_valid;
  assign imm_code  = code;

  always_comb begin
    code        = IM_HIT;
    alloc_en    = 1'b0;
    alloc_hr    = 1'b0;
    alloc_cnt   = CNT_W'(MISS_LAT);
    fill_en     = 1'b0;
    inv_line_en = 1'b0;
    inv_all_en  = 1'b0;
    kill_en     = 1'b0;
    if (req_valid) begin
      unique case (kind)
        RQ_LOAD, RQ_STORE, RQ_PREFETCH: begin
          if (lk_hit && !lk_pend) begin
            code = IM_HIT;
          end else if (lk_hit) begin
            if (free_any) begin
              code      = IM_HIT_SERV;
              alloc_en  = 1'b1;
              alloc_hr  = 1'b1;
              alloc_cnt = q_cnt - CNT_W'(1);
            end else begin
              code = IM_MISS_RETRY;
            end
          end else if (lk_busy || !free_any) begin
            code = IM_MISS_RETRY;
          end else begin
            code     = IM_MISS_SERV;
            alloc_en = 1'b1;
            fill_en  = 1'b1;
          end
        end
        RQ_INV_LINE: begin
          inv_line_en = lk_hit;
          code        = IM_HIT;
        end
        RQ_FLUSH_LINE: begin
          inv_line_en = lk_hit;
          code        = lk_hit ? IM_HIT : IM_MISS_SERV;
        end
        RQ_INV_ALL: begin
          inv_all_en = 1'b1;
          code       = IM_HIT;
        end
        RQ_FLUSH_ALL: begin
          inv_all_en = 1'b1;
          code       = any_valid ? IM_HIT : IM_MISS_SERV;
        end
        RQ_KILL_ALL: begin
          kill_en = 1'b1;
          code    = IM_HIT;
        end
        default: code = IM_HIT;
      endcase
    end
  end

  l1tm_tag_array #(
    .LINES(LINES), .TAG_W(TAG_W), .SLOTS(SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(idx), .lk_tag(tag),
    .lk_hit(lk_hit), .lk_pend(lk_pend), .lk_busy(lk_busy), .lk_slot(lk_slot),
    .any_valid(any_valid),
    .fill_en(fill_en), .fill_slot(free_slot),
    .inv_line_en(inv_line_en), .inv_all_en(inv_all_en), .kill_en(kill_en),
    .done_mask(done_mask)
  );

  l1tm_miss_slots #(
    .SLOTS(SLOTS), .ID_W(ID_W), .LAT(MISS_LAT), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_id(req_id), .alloc_hitresp(alloc_hr),
    .alloc_cnt(alloc_cnt), .kill_en(kill_en),
    .q_slot(lk_slot), .q_cnt(q_cnt),
    .free_any(free_any), .free_slot(free_slot), .done_mask(done_mask),
    .dly_valid(dly_valid), .dly_ready(dly_ready),
    .dly_hitresp(dly_code), .dly_id(dly_id)
  );

  assert_ready_always_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && (imm_valid == req_valid));
endmodule

// File: tb/tb_l1_timing_cache.sv
module tb_l1_timing_cache;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_PF = 3'd2, K_IL = 3'd3,
                         K_IA = 3'd4, K_KA = 3'd5, K_FL = 3'd6, K_FA = 3'd7;
  localparam logic [1:0] C_HIT = 2'd0, C_HS = 2'd1, C_MS = 2'd2, C_RT = 2'd3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, dly_ready = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_id = '0;
  logic        req_ready, imm_valid, dly_valid, dly_code;
  logic [1:0]  imm_code;
  logic [3:0]  dly_id;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  l1_timing_cache #(.ADDR_W(16), .LINES(8), .LINE_BYTES(16), .ID_W(4),
                    .SLOTS(2), .MISS_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_id(req_id),
    .imm_valid(imm_valid), .imm_code(imm_code),
    .dly_valid(dly_valid), .dly_ready(dly_ready), .dly_code(dly_code), .dly_id(dly_id)
  );

  // {kind, addr, id, expected immediate code}
  localparam int NV = 17;
  localparam logic [24:0] VEC [NV] = '{
    {K_LD, 16'h0010, 4'd1, C_MS},   // R3 cold miss
    {K_LD, 16'h0014, 4'd2, C_HIT},  // R12 offset ignored, R2
    {K_ST, 16'h0010, 4'd3, C_HIT},  // R2 store hit
    {K_LD, 16'h0090, 4'd4, C_MS},   // R12 same index, other tag
    {K_LD, 16'h0010, 4'd5, C_MS},   // R12 evicted
    {K_PF, 16'h0020, 4'd6, C_MS},   // R3 prefetch miss
    {K_PF, 16'h0020, 4'd7, C_HIT},  // R2 prefetch hit
    {K_FL, 16'h0010, 4'd0, C_HIT},  // R10 present
    {K_FL, 16'h0010, 4'd0, C_MS},   // R10 absent
    {K_IL, 16'h0020, 4'd0, C_HIT},  // R7 matching tag
    {K_LD, 16'h0020, 4'd8, C_MS},   // R7 line was cleared
    {K_IL, 16'h00A0, 4'd0, C_HIT},  // R7 tag mismatch
    {K_LD, 16'h0020, 4'd9, C_HIT},  // R7 mismatch had no effect
    {K_IA, 16'h0000, 4'd0, C_HIT},  // R8
    {K_LD, 16'h0020, 4'd10, C_MS},  // R8 line gone
    {K_FA, 16'h0000, 4'd0, C_HIT},  // R11 lines present
    {K_FA, 16'h0000, 4'd0, C_MS}    // R11 none present
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [3:0] id,
                       input logic [1:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_id = id;
    #1;
    check(imm_valid && imm_code == exp, req, imm_code, exp);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 reset state
    check(req_ready && !imm_valid && !dly_valid, "R1 reset", {req_ready, imm_valid, dly_valid}, 3'b100);

    // vector table, fills drained between entries
    dly_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][24:22], VEC[i][21:6], VEC[i][5:2], VEC[i][1:0], $sformatf("R2/R3/R7/R8/R10/R11/R12 vec%0d", i));
      idle(LAT + 2);
    end

    // R3 exact latency and id
    dly_ready = 1'b0;
    issue(K_LD, 16'h0100, 4'd5, C_MS, "R3 miss");
    idle(LAT - 1);
    @(negedge clk); #1;
    check(!dly_valid, "R3 not early", dly_valid, 0);
    @(posedge clk); @(negedge clk); #1;
    check(dly_valid && dly_code == 1'b0 && dly_id == 4'd5, "R3 response", {dly_valid, dly_code, dly_id}, {1'b1, 1'b0, 4'd5});
    // R6 hold while not ready
    repeat (3) @(negedge clk); #1;
    check(dly_valid && dly_id == 4'd5, "R6 hold", {dly_valid, dly_id}, {1'b1, 4'd5});
    dly_ready = 1'b1;
    @(posedge clk); @(negedge clk); dly_ready = 1'b0; #1;
    check(!dly_valid, "R6 popped", dly_valid, 0);

    // R4 pending hit, R5 retries when slots are full
    issue(K_LD, 16'h0140, 4'd1, C_MS, "R4 fill");
    issue(K_LD, 16'h0144, 4'd2, C_HS, "R4 hit servicing");
    issue(K_LD, 16'h0150, 4'd3, C_RT, "R5 no slot miss");
    issue(K_LD, 16'h0144, 4'd4, C_RT, "R5 no slot pending hit");
    @(negedge clk); req_valid = 1'b0; #1;
    check(!dly_valid, "R4 not early", dly_valid, 0);
    @(posedge clk); @(negedge clk); #1;
    check(dly_valid && dly_code == 1'b0 && dly_id == 4'd1, "R6 lowest slot first", {dly_valid, dly_code, dly_id}, {1'b1, 1'b0, 4'd1});
    dly_ready = 1'b1;
    @(posedge clk); @(negedge clk); dly_ready = 1'b0; #1;
    check(dly_valid && dly_code == 1'b1 && dly_id == 4'd2, "R4 hit response", {dly_valid, dly_code, dly_id}, {1'b1, 1'b1, 4'd2});
    dly_ready = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    check(!dly_valid, "R4 drained", dly_valid, 0);
    issue(K_LD, 16'h0150, 4'd3, C_MS, "R5 retry left no line");
    issue(K_LD, 16'h01D0, 4'd6, C_RT, "R5 index busy other tag");
    idle(LAT + 2);

    // R9 kill
    dly_ready = 1'b0;
    issue(K_LD, 16'h0160, 4'd7, C_MS, "R9 miss before kill");
    issue(K_KA, 16'h0000, 4'd0, C_HIT, "R9 kill");
    idle(LAT + 2);
    @(negedge clk); #1;
    check(!dly_valid, "R9 no response after kill", dly_valid, 0);
    issue(K_LD, 16'h0160, 4'd8, C_MS, "R9 pending line dropped");
    issue(K_LD, 16'h0170, 4'd9, C_MS, "R9 slots freed");
    issue(K_KA, 16'h0000, 4'd0, C_HIT, "R9 kill again");
    idle(2);
    report();
  end
endmodule